// File: doc/BRIEF.md
# Inbound Virtual Wire Bank

This block keeps a bank of registers for virtual wires that the host drives towards the device. Each register stands for one host wire group. It holds an 8-bit host index and four single-bit wire states. The link side presents an index together with a data byte. The register whose index matches takes the new values, but only for the wires that the byte marks as valid. Each wire can raise a sticky interrupt status bit. Its 4-bit select code chooses a level mode, an edge mode, or no interrupt.

Firmware sets up each register through a byte-enabled write port. It programs the host index, the reset domain, the reset values, the per-wire select codes and the wire states. Each of these fields sits in its own byte lane, so one lane can be changed without touching the others. A combinational read port returns the same layout. Four domain reset inputs reload the wire states of every register bound to that domain. The status bits are split into two words by register number. They are cleared by writing ones. A wake output is raised only by status bits whose wire uses an edge mode.

Top module: `vw_inbound_bank`

## Requirements
- R1: After `rstN` is released, every index is 0x00, every reset domain and reset value is 0, every select code is 0x4, every wire state is 0, both status words are zero and `wake` is low.
- R2: The register address is reg*4+word. Word 0 holds the index in byte 0, and the reset control in byte 1: domain in bits [9:8], reset values in bits [15:12]. Word 1 holds the select of wire n in bits [8n+3:8n]. Word 2 holds the state of wire n in bit 8n. A write changes only the enabled bytes. Word 3 and registers 11 and above ignore writes and read as zero. Unused read bits are zero.
- R3: A link update with `updValid` high applies at that clock edge. For each wire n whose flag `updData[4+n]` is 1, the matching register sets the state to `updData[n]`. Wires whose flag is 0 keep their state.
- R4: A link update whose index matches no register changes no state and no status.
- R5: When several registers hold the update's index, only the lowest-numbered one is updated.
- R6: While `domRst[k]` is high at a clock edge, every register whose domain is k loads its four reset values into its wire states. This takes priority over updates and firmware writes in that cycle. Registers bound to other domains are not affected.
- R7: Code 0x1 (level high) and code 0x0 (level low) set the wire's status one cycle after the state matches the level. Status is sticky. A clear bit wins in its own cycle, and the status is set again one cycle later while the level still holds.
- R8: Code 0xE sets status on a 0-to-1 change of the state, 0xD on a 1-to-0 change, and 0xF on either. The status is set at the same edge that changes the state, and an edge event overrides a clear in the same cycle. After a clear it is not set again until the next edge.
- R9: Code 0x4, and every code other than 0x0, 0x1, 0xD, 0xE and 0xF, never sets status.
- R10: Status for register r < 7, wire w, is `statusA[r*4+w]`. For r >= 7 it is `statusB[(r-7)*4+w]`.
- R11: `wake` is high exactly when some status bit is set and that wire's select code is currently an edge code.
- R12: When a firmware state write and a link update hit the same wire in the same cycle, the firmware value wins. The other flagged wires of the update still apply.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low block reset |
| domRst | input | 4 | Domain reset requests, bit k = domain k, active high |
| updValid | input | 1 | Link update strobe |
| updIndex | input | 8 | Host index of the update |
| updData | input | 8 | [7:4] per-wire valid flags, [3:0] new states |
| wrEn | input | 1 | Firmware write strobe |
| wrAddr | input | 6 | Firmware write address, reg*4+word |
| wrBe | input | 4 | Byte enables for the write |
| wrData | input | 32 | Write data |
| rdAddr | input | 6 | Read address, reg*4+word |
| rdData | output | 32 | Combinational read data |
| clrA | input | 28 | Write-one-to-clear mask for status word A |
| clrB | input | 16 | Write-one-to-clear mask for status word B |
| statusA | output | 28 | Sticky status, registers 0 to 6 |
| statusB | output | 16 | Sticky status, registers 7 to 10 |
| wake | output | 1 | Wake request from edge-mode status |

## Verification
A corrupted index or a wrong priority shows on the very next read of the state word: the wrong register takes the update, or none does. A wrong select decode or a wrong status mapping shows in the status words. With edge codes it shows at the update edge itself. With level codes it shows one cycle later, so the bench samples both status words in every cycle around each event. A missing domain reload, or a lost firmware write, shows as the wrong state word right after that edge. A clear that loses to, or beats, the wrong source shows in the cycle after the clear strobe.

// File: rtl/vwib_pkg.sv
`timescale 1ns/1ps
package vwib_pkg;
  localparam int VW_WIRES  = 4;
  localparam int VW_IDX_W  = 8;
  localparam int VW_REG_AW = 4;
  localparam int VW_ADDR_W = VW_REG_AW + 2;
  localparam int VW_SRC_N  = 4;

  localparam logic [3:0] SEL_LVL_LO = 4'h0;
  localparam logic [3:0] SEL_LVL_HI = 4'h1;
  localparam logic [3:0] SEL_OFF    = 4'h4;
  localparam logic [3:0] SEL_FALL   = 4'hD;
  localparam logic [3:0] SEL_RISE   = 4'hE;
  localparam logic [3:0] SEL_BOTH   = 4'hF;

  localparam logic [1:0] WORD_CFG   = 2'd0;
  localparam logic [1:0] WORD_SEL   = 2'd1;
  localparam logic [1:0] WORD_STATE = 2'd2;

  typedef struct packed {
    logic                 updHit;
    logic [VW_REG_AW-1:0] updReg;
    logic [VW_WIRES-1:0]  updMask;
    logic [VW_WIRES-1:0]  updVal;
    logic                 wrHit;
    logic [VW_REG_AW-1:0] wrReg;
    logic [1:0]           wrWord;
    logic [3:0]           wrBe;
    logic [31:0]          wrData;
  } vwStrobe_t;
endpackage

// File: rtl/vwib_ctrl.sv
`timescale 1ns/1ps
module vwib_ctrl
  import vwib_pkg::*;
#(
  parameter int NUM_REGS = 11
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         updValid,
  input  logic [VW_IDX_W-1:0]          updIndex,
  input  logic [7:0]                   updData,
  input  logic                         wrEn,
  input  logic [VW_ADDR_W-1:0]         wrAddr,
  input  logic [3:0]                   wrBe,
  input  logic [31:0]                  wrData,
  input  logic [NUM_REGS*VW_IDX_W-1:0] idxFlat,
  output vwStrobe_t                    strb
);

  // Priority search: scan from the top so the lowest matching register is
  // written last and therefore wins.
  always_comb begin
    strb = '0;
    for (int r = NUM_REGS - 1; r >= 0; r--) begin
      if (updValid && (idxFlat[r*VW_IDX_W +: VW_IDX_W] == updIndex)) begin
        strb.updHit = 1'b1;
        strb.updReg = VW_REG_AW'(r);
      end
    end
    strb.updMask = updData[7:4];
    strb.updVal  = updData[3:0];
    strb.wrReg   = wrAddr[VW_ADDR_W-1:2];
    strb.wrWord  = wrAddr[1:0];
    strb.wrBe    = wrBe;
    strb.wrData  = wrData;
    strb.wrHit   = wrEn && (int'(wrAddr[VW_ADDR_W-1:2]) < NUM_REGS)
                   && (wrAddr[1:0] != 2'd3);
  end

  for (genvar j = 0; j < NUM_REGS; j++) begin : g_chk
    // R5
    lowest_win_chk: assert property (@(posedge clk) disable iff (!rstN)
      (strb.updHit && (int'(strb.updReg) > j)) |->
        (idxFlat[j*VW_IDX_W +: VW_IDX_W] != updIndex));
    // R4
    no_match_chk: assert property (@(posedge clk) disable iff (!rstN)
      (updValid && !strb.updHit) |->
        (idxFlat[j*VW_IDX_W +: VW_IDX_W] != updIndex));
  end

endmodule

// File: rtl/vwib_datapath.sv
`timescale 1ns/1ps
module vwib_datapath
  import vwib_pkg::*;
#(
  parameter int NUM_REGS = 11
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  vwStrobe_t                    strb,
  input  logic [VW_SRC_N-1:0]          domRst,
  input  logic [NUM_REGS*VW_WIRES-1:0] clrFlat,
  input  logic [VW_ADDR_W-1:0]         rdAddr,
  output logic [NUM_REGS*VW_IDX_W-1:0] idxFlat,
  output logic [NUM_REGS*VW_WIRES-1:0] stsFlat,
  output logic                         wake,
  output logic [31:0]                  rdData
);
  localparam int NB      = NUM_REGS * VW_WIRES;
  localparam int SEL_W   = VW_WIRES * 4;

  logic [NB-1:0]             stsQ;
  logic [NB-1:0]             stsNext;
  logic [NB-1:0]             edgeMode;
  logic [NUM_REGS*8-1:0]     ctlFlat;
  logic [NUM_REGS*SEL_W-1:0] selFlat;
  logic [NB-1:0]             stFlat;
  logic                      unusedBits;

  assign unusedBits = ^{strb.wrData[31:28], strb.wrData[23:20]};

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    localparam logic [VW_REG_AW-1:0] RID = VW_REG_AW'(r);

    logic [VW_IDX_W-1:0] idxQ;
    logic [1:0]          srcQ;
    logic [3:0]          rvalQ;
    logic [3:0]          selQ [VW_WIRES];
    logic [3:0]          stQ;
    logic [3:0]          stNext;
    logic                wrMe;
    logic                updMe;
    logic                rstMe;

    assign wrMe  = strb.wrHit && (strb.wrReg == RID);
    assign updMe = strb.updHit && (strb.updReg == RID);
    assign rstMe = domRst[srcQ];

    always_ff @(posedge clk) begin
      if (!rstN) begin
        idxQ  <= '0;
        srcQ  <= '0;
        rvalQ <= '0;
        for (int w = 0; w < VW_WIRES; w++) selQ[w] <= SEL_OFF;
      end else if (wrMe) begin
        if (strb.wrWord == WORD_CFG) begin
          if (strb.wrBe[0]) idxQ <= strb.wrData[7:0];
          if (strb.wrBe[1]) begin
            srcQ  <= strb.wrData[9:8];
            rvalQ <= strb.wrData[15:12];
          end
        end
        if (strb.wrWord == WORD_SEL) begin
          for (int w = 0; w < VW_WIRES; w++)
            if (strb.wrBe[w]) selQ[w] <= strb.wrData[w*8 +: 4];
        end
      end
    end

    // Next state: link update, then firmware write, then domain reset.
    always_comb begin
      stNext = stQ;
      for (int w = 0; w < VW_WIRES; w++) begin
        if (updMe && strb.updMask[w]) stNext[w] = strb.updVal[w];
        if (wrMe && (strb.wrWord == WORD_STATE) && strb.wrBe[w])
          stNext[w] = strb.wrData[w*8];
      end
      if (rstMe) stNext = rvalQ;
    end

    always_ff @(posedge clk) begin
      if (!rstN) stQ <= '0;
      else       stQ <= stNext;
    end

    assign idxFlat[r*VW_IDX_W +: VW_IDX_W] = idxQ;
    assign ctlFlat[r*8 +: 8]               = {rvalQ, 2'b00, srcQ};
    assign stFlat[r*VW_WIRES +: VW_WIRES]  = stQ;

    for (genvar w = 0; w < VW_WIRES; w++) begin : g_wire
      localparam int B = r * VW_WIRES + w;
      logic rose;
      logic fell;
      logic edgeEv;
      logic lvlEv;
      logic lvlMode;

      assign selFlat[r*SEL_W + w*4 +: 4] = selQ[w];
      assign rose     = !stQ[w] && stNext[w];
      assign fell     = stQ[w] && !stNext[w];
      assign edgeMode[B] = (selQ[w] == SEL_FALL) || (selQ[w] == SEL_RISE)
                           || (selQ[w] == SEL_BOTH);
      assign lvlMode  = (selQ[w] == SEL_LVL_LO) || (selQ[w] == SEL_LVL_HI);
      assign edgeEv   = ((selQ[w] == SEL_RISE) && rose)
                      | ((selQ[w] == SEL_FALL) && fell)
                      | ((selQ[w] == SEL_BOTH) && (rose || fell));
      assign lvlEv    = ((selQ[w] == SEL_LVL_LO) && !stQ[w])
                      | ((selQ[w] == SEL_LVL_HI) && stQ[w]);
      assign stsNext[B] = edgeEv | ((stsQ[B] | lvlEv) & ~clrFlat[B]);

      // R9
      quiet_sel_chk: assert property (@(posedge clk) disable iff (!rstN)
        (!edgeMode[B] && !lvlMode && !stsQ[B]) |=> !stsQ[B]);
      // R7
      clr_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
        (!edgeMode[B] && clrFlat[B]) |=> !stsQ[B]);
      // R8
      rise_set_chk: assert property (@(posedge clk) disable iff (!rstN)
        ((selQ[w] == SEL_RISE) && !stQ[w] && stNext[w]) |=> stsQ[B]);
    end

    // R6
    dom_load_chk: assert property (@(posedge clk) disable iff (!rstN)
      rstMe |=> (stQ == $past(rvalQ)));
  end

  always_ff @(posedge clk) begin
    if (!rstN) stsQ <= '0;
    else       stsQ <= stsNext;
  end

  assign stsFlat = stsQ;
  assign wake    = |(stsQ & edgeMode);

  logic [VW_REG_AW-1:0] rdReg;
  logic [1:0]           rdWord;
  assign rdReg  = rdAddr[VW_ADDR_W-1:2];
  assign rdWord = rdAddr[1:0];

  always_comb begin
    rdData = '0;
    if (int'(rdReg) < NUM_REGS) begin
      case (rdWord)
        WORD_CFG: begin
          rdData[7:0]  = idxFlat[int'(rdReg)*VW_IDX_W +: VW_IDX_W];
          rdData[15:8] = ctlFlat[int'(rdReg)*8 +: 8];
        end
        WORD_SEL: begin
          for (int w = 0; w < VW_WIRES; w++)
            rdData[w*8 +: 4] = selFlat[int'(rdReg)*SEL_W + w*4 +: 4];
        end
        WORD_STATE: begin
          for (int w = 0; w < VW_WIRES; w++)
            rdData[w*8] = stFlat[int'(rdReg)*VW_WIRES + w];
        end
        default: rdData = '0;
      endcase
    end
  end

endmodule

// File: rtl/vw_inbound_bank.sv
`timescale 1ns/1ps
module vw_inbound_bank
  import vwib_pkg::*;
#(
  parameter int NUM_REGS  = 11,
  parameter int SPLIT_REG = 7
) (
  input  logic                                   clk,
  input  logic                                   rstN,
  input  logic [VW_SRC_N-1:0]                    domRst,
  input  logic                                   updValid,
  input  logic [VW_IDX_W-1:0]                    updIndex,
  input  logic [7:0]                             updData,
  input  logic                                   wrEn,
  input  logic [VW_ADDR_W-1:0]                   wrAddr,
  input  logic [3:0]                             wrBe,
  input  logic [31:0]                            wrData,
  input  logic [VW_ADDR_W-1:0]                   rdAddr,
  output logic [31:0]                            rdData,
  input  logic [SPLIT_REG*VW_WIRES-1:0]          clrA,
  input  logic [(NUM_REGS-SPLIT_REG)*VW_WIRES-1:0] clrB,
  output logic [SPLIT_REG*VW_WIRES-1:0]          statusA,
  output logic [(NUM_REGS-SPLIT_REG)*VW_WIRES-1:0] statusB,
  output logic                                   wake
);
  localparam int NB  = NUM_REGS * VW_WIRES;
  localparam int A_W = SPLIT_REG * VW_WIRES;

  vwStrobe_t                    strb;
  logic [NUM_REGS*VW_IDX_W-1:0] idxFlat;
  logic [NB-1:0]                stsFlat;
  logic [NB-1:0]                clrFlat;

  // Flat status bit r*4+w splits at the register boundary into the two words.
  assign clrFlat = {clrB, clrA};
  assign statusA = stsFlat[A_W-1:0];
  assign statusB = stsFlat[NB-1:A_W];

  vwib_ctrl #(.NUM_REGS(NUM_REGS)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .updValid (updValid),
    .updIndex (updIndex),
    .updData  (updData),
    .wrEn     (wrEn),
    .wrAddr   (wrAddr),
    .wrBe     (wrBe),
    .wrData   (wrData),
    .idxFlat  (idxFlat),
    .strb     (strb)
  );

  vwib_datapath #(.NUM_REGS(NUM_REGS)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .domRst  (domRst),
    .clrFlat (clrFlat),
    .rdAddr  (rdAddr),
    .idxFlat (idxFlat),
    .stsFlat (stsFlat),
    .wake    (wake),
    .rdData  (rdData)
  );

endmodule

// File: tb/vw_inbound_bank_tb.sv
`timescale 1ns/1ps
module vw_inbound_bank_tb;
  logic        clk = 1'b0;
  logic        rstN;
  logic [3:0]  domRst;
  logic        updValid;
  logic [7:0]  updIndex;
  logic [7:0]  updData;
  logic        wrEn;
  logic [5:0]  wrAddr;
  logic [3:0]  wrBe;
  logic [31:0] wrData;
  logic [5:0]  rdAddr;
  logic [31:0] rdData;
  logic [27:0] clrA;
  logic [15:0] clrB;
  logic [27:0] statusA;
  logic [15:0] statusB;
  logic        wake;

  int nRun  = 0;
  int nFail = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  vw_inbound_bank u_dut (
    .clk(clk), .rstN(rstN), .domRst(domRst), .updValid(updValid),
    .updIndex(updIndex), .updData(updData), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrBe(wrBe), .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData),
    .clrA(clrA), .clrB(clrB), .statusA(statusA), .statusB(statusB),
    .wake(wake)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic checkRd(string req, int r, int word, logic [31:0] exp);
    rdAddr = {4'(r), 2'(word)};
    #1;
    chk(req, $sformatf("read reg%0d word%0d", r, word), rdData, exp);
  endtask

  task automatic checkSts(string req, logic [27:0] expA, logic [15:0] expB);
    chk(req, "statusA", {4'h0, statusA}, {4'h0, expA});
    chk(req, "statusB", {16'h0, statusB}, {16'h0, expB});
  endtask

  task automatic fwWrite(int r, int word, logic [3:0] be, logic [31:0] d);
    wrEn = 1'b1; wrAddr = {4'(r), 2'(word)}; wrBe = be; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; wrBe = 4'h0;
  endtask

  task automatic busUpd(logic [7:0] idx, logic [7:0] d);
    updValid = 1'b1; updIndex = idx; updData = d;
    @(negedge clk);
    updValid = 1'b0;
  endtask

  task automatic clrPulse(logic [27:0] a, logic [15:0] b);
    clrA = a; clrB = b;
    @(negedge clk);
    clrA = '0; clrB = '0;
  endtask

  task automatic domPulse(logic [3:0] d);
    domRst = d;
    @(negedge clk);
    domRst = 4'h0;
  endtask

  task automatic testReset();
    checkSts("R1", 28'h0, 16'h0);
    chk("R1", "wake", {31'h0, wake}, 32'h0);
    checkRd("R1", 0, 1, 32'h04040404);
    checkRd("R1", 10, 1, 32'h04040404);
    checkRd("R1", 0, 0, 32'h0);
    checkRd("R1", 10, 2, 32'h0);
  endtask

  task automatic testBytes();
    fwWrite(3, 0, 4'b0001, 32'hFFFF_FF47);
    checkRd("R2", 3, 0, 32'h0000_0047);
    fwWrite(3, 0, 4'b0010, 32'h0000_A2FF);
    checkRd("R2", 3, 0, 32'h0000_A247);
    fwWrite(3, 0, 4'b1100, 32'hFFFF_FFFF);
    checkRd("R2", 3, 0, 32'h0000_A247);
    fwWrite(3, 1, 4'b0100, 32'h0F07_0F0F);
    checkRd("R2", 3, 1, 32'h0407_0404);
    fwWrite(3, 3, 4'b1111, 32'hFFFF_FFFF);
    checkRd("R2", 3, 3, 32'h0);
    fwWrite(12, 0, 4'b1111, 32'h0000_0099);
    checkRd("R2", 12, 0, 32'h0);
  endtask

  task automatic testUpdate();
    busUpd(8'h47, 8'hF5);
    checkRd("R3", 3, 2, 32'h0001_0001);
    busUpd(8'h47, 8'h2A);
    checkRd("R3", 3, 2, 32'h0001_0101);
    checkSts("R9", 28'h0, 16'h0);
  endtask

  task automatic testUnmatched();
    busUpd(8'h99, 8'hF0);
    checkRd("R4", 3, 2, 32'h0001_0101);
    checkSts("R4", 28'h0, 16'h0);
  endtask

  task automatic testPriority();
    busUpd(8'h00, 8'h11);
    checkRd("R5", 0, 2, 32'h0000_0001);
    checkRd("R5", 1, 2, 32'h0);
    checkRd("R5", 2, 2, 32'h0);
    busUpd(8'h00, 8'h10);
    checkRd("R5", 0, 2, 32'h0);
  endtask

  task automatic testDomain();
    domPulse(4'b0010);
    checkRd("R6", 3, 2, 32'h0001_0101);
    domPulse(4'b0100);
    checkRd("R6", 3, 2, 32'h0100_0100);
    checkRd("R6", 4, 2, 32'h0);
  endtask

  task automatic testFwWins();
    updValid = 1'b1; updIndex = 8'h47; updData = 8'h55;
    wrEn = 1'b1; wrAddr = {4'd3, 2'd2}; wrBe = 4'b0001; wrData = 32'h0;
    @(negedge clk);
    updValid = 1'b0; wrEn = 1'b0; wrBe = 4'h0;
    checkRd("R12", 3, 2, 32'h0101_0100);
  endtask

  task automatic testDisabled();
    fwWrite(5, 2, 4'b1111, 32'h0101_0101);
    fwWrite(5, 1, 4'b0001, 32'h0000_0009);
    fwWrite(5, 2, 4'b0001, 32'h0);
    @(negedge clk);
    checkRd("R9", 5, 2, 32'h0101_0100);
    checkSts("R9", 28'h0, 16'h0);
  endtask

  task automatic testLevel();
    fwWrite(4, 0, 4'b0001, 32'h60);
    fwWrite(4, 1, 4'b0001, 32'h1);
    @(negedge clk);
    checkSts("R7", 28'h0, 16'h0);
    busUpd(8'h60, 8'h11);
    checkSts("R7", 28'h0, 16'h0);
    @(negedge clk);
    checkSts("R10", 28'h001_0000, 16'h0);
    chk("R11", "wake level", {31'h0, wake}, 32'h0);
    clrPulse(28'h001_0000, 16'h0);
    checkSts("R7", 28'h0, 16'h0);
    @(negedge clk);
    checkSts("R7", 28'h001_0000, 16'h0);
    busUpd(8'h60, 8'h10);
    clrPulse(28'h001_0000, 16'h0);
    @(negedge clk);
    checkSts("R7", 28'h0, 16'h0);
    fwWrite(4, 1, 4'b0010, 32'h0);
    @(negedge clk);
    checkSts("R7", 28'h002_0000, 16'h0);
    fwWrite(4, 1, 4'b0010, 32'h0000_0400);
    clrPulse(28'h002_0000, 16'h0);
    @(negedge clk);
    checkSts("R7", 28'h0, 16'h0);
  endtask

  task automatic testRise();
    fwWrite(8, 0, 4'b0001, 32'h81);
    fwWrite(8, 1, 4'b0100, 32'h000E_0000);
    busUpd(8'h81, 8'h44);
    checkSts("R8", 28'h0, 16'h0040);
    chk("R11", "wake rise", {31'h0, wake}, 32'h1);
    clrPulse(28'h0, 16'h0040);
    checkSts("R8", 28'h0, 16'h0);
    chk("R11", "wake cleared", {31'h0, wake}, 32'h0);
    @(negedge clk);
    checkSts("R8", 28'h0, 16'h0);
    busUpd(8'h81, 8'h40);
    checkSts("R8", 28'h0, 16'h0);
  endtask

  task automatic testFall();
    fwWrite(10, 0, 4'b0001, 32'hA0);
    fwWrite(10, 1, 4'b1000, 32'h0D00_0000);
    fwWrite(10, 2, 4'b1000, 32'h0100_0000);
    checkSts("R8", 28'h0, 16'h0);
    checkRd("R2", 10, 2, 32'h0100_0000);
    busUpd(8'hA0, 8'h80);
    checkSts("R10", 28'h0, 16'h8000);
    chk("R11", "wake fall", {31'h0, wake}, 32'h1);
    clrPulse(28'h0, 16'h8000);
    checkSts("R8", 28'h0, 16'h0);
  endtask

  task automatic testBoth();
    fwWrite(0, 1, 4'b0001, 32'hF);
    busUpd(8'h00, 8'h11);
    checkSts("R8", 28'h1, 16'h0);
    clrPulse(28'h1, 16'h0);
    checkSts("R8", 28'h0, 16'h0);
    busUpd(8'h00, 8'h10);
    checkSts("R8", 28'h1, 16'h0);
    clrPulse(28'h1, 16'h0);
    updValid = 1'b1; updIndex = 8'h00; updData = 8'h11; clrA = 28'h1;
    @(negedge clk);
    updValid = 1'b0; clrA = '0;
    checkSts("R8", 28'h1, 16'h0);
    chk("R11", "wake both", {31'h0, wake}, 32'h1);
    clrPulse(28'h1, 16'h0);
    checkSts("R8", 28'h0, 16'h0);
    chk("R11", "wake idle", {31'h0, wake}, 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nRun++;
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; domRst = 4'h0; updValid = 1'b0; updIndex = 8'h0;
    updData = 8'h0; wrEn = 1'b0; wrAddr = '0; wrBe = 4'h0; wrData = '0;
    rdAddr = '0; clrA = '0; clrB = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testBytes();
    testUpdate();
    testUnmatched();
    testPriority();
    testDomain();
    testFwWins();
    testDisabled();
    testLevel();
    testRise();
    testFall();
    testBoth();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule